// File: doc/BRIEF.md
# Input Frame Offset Meter

This block times how late one of several frame-evaluation inputs falls, measured from the falling edge of the master frame pulse. The result is reported in whole clock cycles plus one half-cycle bit. Software uses it to size the receive delay of a backplane stream. It picks one of 32 active-low evaluation inputs with a 5-bit select. A measurement starts on a low-to-high transition of a start bit. The block returns a 16-bit status word that carries the select value, a completion flag, the phase bit and a 9-bit cycle count.

A measurement covers one whole frame. The first frame-pulse falling edge after the start opens the frame. The count then runs until the selected input falls. The completion flag rises at the next frame-pulse falling edge, two frames after the start. The flag drops when the start bit returns low, and a fresh measurement needs another low-to-high transition. The frame pulse and the selected input pass through synchronizers of the same depth, so the synchronizer delay cancels out of the result.

Top module: `frame_offset_meter`

## Requirements
- R1: After reset the completion flag (status[10]), the phase bit (status[9]) and the count (status[8:0]) read zero.
- R2: status[15:11] always shows the current value of the select input. status[10] is the completion flag, status[9] the phase bit, status[8:0] the count.
- R3: A 0-to-1 change of the start bit arms the meter. The first frame-pulse falling edge after arming opens the measured frame. The completion flag rises at the second frame-pulse falling edge after arming and stays set.
- R4: Each falling edge is timed to the first rising clock edge after it. The count is the number of clock periods from the frame-pulse edge to the first falling edge of the selected input within the measured frame. An input edge timed to the same clock as the frame-pulse edge gives a count of 0.
- R5: The phase bit is 1 when the counted input edge came in the high half of the clock period, and 0 when it came in the low half.
- R6: These edges do not change the count or the phase bit: falling edges of the selected input before the measured frame opens, later falling edges in the same frame, and falling edges of any input that is not selected.
- R7: The count saturates at 511. If the selected input does not fall before the closing frame pulse, the result is count 511 with phase 0.
- R8: A 1-to-0 change of the start bit clears the completion flag on the next clock and keeps count and phase. If a measurement is running, it is abandoned, and later frame pulses do not set the flag.
- R9: While the start bit stays at 1 after completion, further frame pulses and input edges leave the whole result unchanged.
- R10: The select value is captured at the start transition. Changing the select input during a measurement changes only status[15:11], not which input is measured.
- R11: A start transition clears the count, the phase bit and the completion flag to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Master frame pulse, active low |
| eval_n | input | 32 | Frame-evaluation inputs, measured on their falling edge |
| eval_sel | input | 5 | Number of the evaluation input to measure |
| meas_start | input | 1 | Start bit; a 0-to-1 change launches a measurement |
| status | output | 16 | Select echo, completion flag, phase bit and cycle count |

## Verification
The bench steers input edges into a chosen half of the clock period. A design that sampled on only one clock phase would report the wrong phase bit. Edges that land on the same clock as the frame pulse must give a count of 0, and an off-by-one in either synchronizer path shows up there. A frame with no edge, and a frame longer than 511 cycles, test the saturation value: a design that wrapped the counter or left a stale count would fail them. The bench also fires edges on unselected inputs, changes the select mid-frame, holds the start bit high past completion and drops it mid-measurement, so a design that re-latched the select, re-armed itself or missed the abort is caught.

// File: rtl/fom_pkg.sv
package fom_pkg;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ARMED = 2'd1,
    MS_COUNT = 2'd2,
    MS_DONE  = 2'd3
  } meas_state_e;

  // Saturating increment: stays at lim once reached.
  function automatic int unsigned sat_incr(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // High-to-low transition between an older and a newer sample.
  function automatic logic fall_of(input logic older, input logic newer);
    return older & ~newer;
  endfunction

endpackage

// File: rtl/fom_sync_fall.sv
module fom_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  import fom_pkg::*;

  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign fall = fall_of(chain[STAGES], chain[STAGES-1]);

  // A detected edge lasts exactly one clock.
  assert_fall_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/fom_phase_tap.sv
module fom_phase_tap #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fell_in_high
);
  logic            half_samp;
  logic [STAGES-1:0] hchain;

  // Sampled at the end of the high half of each period.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half_samp <= 1'b1;
    else        half_samp <= din;
  end

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hchain <= '1;
        else        hchain <= half_samp;
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hchain <= '1;
        else        hchain <= {hchain[STAGES-2:0], half_samp};
      end
    end
  endgenerate

  // Low already at the mid-period sample means the edge was in the high half.
  assign fell_in_high = ~hchain[STAGES-1];

endmodule

// File: rtl/fom_ctrl.sv
module fom_ctrl #(
  parameter int SEL_W = 5,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  input  logic             fp_fall,
  input  logic             ev_fall,
  input  logic             ev_phase,
  output logic [SEL_W-1:0] sel_q,
  output logic             done,
  output logic             phase,
  output logic [CNT_W-1:0] count
);
  import fom_pkg::*;

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  meas_state_e st;
  logic        start_q;
  logic        found;
  logic        start_rise;
  logic        start_fall;

  assign start_rise = start & ~start_q;
  assign start_fall = fall_of(start_q, start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= MS_IDLE;
      start_q <= 1'b0;
      sel_q   <= '0;
      done    <= 1'b0;
      phase   <= 1'b0;
      count   <= '0;
      found   <= 1'b0;
    end else begin
      start_q <= start;
      if (start_fall) begin
        st   <= MS_IDLE;
        done <= 1'b0;
      end else if (start_rise) begin
        st    <= MS_ARMED;
        sel_q <= sel;
        count <= '0;
        phase <= 1'b0;
        found <= 1'b0;
        done  <= 1'b0;
      end else begin
        unique case (st)
          MS_ARMED: begin
            if (fp_fall) begin
              st    <= MS_COUNT;
              count <= '0;
              if (ev_fall) begin
                found <= 1'b1;
                phase <= ev_phase;
              end
            end
          end
          MS_COUNT: begin
            if (fp_fall) begin
              st   <= MS_DONE;
              done <= 1'b1;
              if (!found) begin
                count <= CNT_W'(CNT_MAX);
                phase <= 1'b0;
              end
            end else if (!found) begin
              count <= CNT_W'(sat_incr(32'(count), CNT_MAX));
              if (ev_fall) begin
                found <= 1'b1;
                phase <= ev_phase;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_done_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fp_fall));

  assert_done_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  assert_count_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(CNT_MAX) && !start_rise) |=> (count == CNT_W'(CNT_MAX)));

  assert_miss_gives_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(found)) |-> (count == CNT_W'(CNT_MAX) && !phase));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(count) && $stable(phase)));

endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter #(
  parameter int N_EVAL      = 32,
  parameter int SEL_W       = $clog2(N_EVAL),
  parameter int CNT_W       = 9,
  parameter int SYNC_STAGES = 2,
  localparam int STAT_W     = SEL_W + 2 + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [N_EVAL-1:0] eval_n,
  input  logic [SEL_W-1:0]  eval_sel,
  input  logic              meas_start,
  output logic [STAT_W-1:0] status
);
  logic [SEL_W-1:0] sel_q;
  logic             picked;
  logic             fp_fall;
  logic             ev_fall;
  logic             ev_phase;
  logic             done;
  logic             phase;
  logic [CNT_W-1:0] count;

  assign picked = eval_n[sel_q];

  fom_sync_fall #(.STAGES(SYNC_STAGES)) u_fp_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (frame_n),
    .fall (fp_fall)
  );

  fom_sync_fall #(.STAGES(SYNC_STAGES)) u_ev_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (picked),
    .fall (ev_fall)
  );

  fom_phase_tap #(.STAGES(SYNC_STAGES)) u_ev_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .din         (picked),
    .fell_in_high(ev_phase)
  );

  fom_ctrl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (meas_start),
    .sel     (eval_sel),
    .fp_fall (fp_fall),
    .ev_fall (ev_fall),
    .ev_phase(ev_phase),
    .sel_q   (sel_q),
    .done    (done),
    .phase   (phase),
    .count   (count)
  );

  assign status = {eval_sel, done, phase, count};

endmodule

// File: tb/frame_offset_meter_tb.sv
module frame_offset_meter_tb;
  localparam int MAXC = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n;
  logic [31:0] eval_n;
  logic [4:0]  eval_sel;
  logic        meas_start;
  logic [15:0] status;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  string cur_req = "R1";

  // event records, indexed by the clock after which the edge was driven
  bit fp_mark [MAXC];
  int ev_line [MAXC];
  bit ev_hi   [MAXC];

  // behavioural reference state
  int m_state = 0;      // 0 idle, 1 armed, 2 counting, 3 complete
  bit m_start_q = 0;
  int m_sel = 0;
  int m_count = 0;
  bit m_phase = 0;
  bit m_found = 0;
  bit m_done = 0;

  always #2 clk = ~clk;

  frame_offset_meter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .eval_n(eval_n),
    .eval_sel(eval_sel), .meas_start(meas_start), .status(status)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [15:0] expected_word();
    return {eval_sel, m_done, m_phase, 9'(m_count)};
  endfunction

  task automatic model_step();
    bit fpe, eve, evp, rise, fall;
    fpe = (cyc >= 3) && fp_mark[cyc-3];
    eve = (cyc >= 3) && (ev_line[cyc-3] == m_sel);
    evp = (cyc >= 3) && ev_hi[cyc-3];
    rise = meas_start && !m_start_q;
    fall = !meas_start && m_start_q;
    m_start_q = meas_start;
    if (fall) begin
      m_state = 0; m_done = 0;
    end else if (rise) begin
      m_state = 1; m_sel = int'(eval_sel); m_count = 0; m_phase = 0; m_found = 0; m_done = 0;
    end else if (m_state == 1) begin
      if (fpe) begin
        m_state = 2; m_count = 0;
        if (eve) begin m_found = 1; m_phase = evp; end
      end
    end else if (m_state == 2) begin
      if (fpe) begin
        m_state = 3; m_done = 1;
        if (!m_found) begin m_count = 511; m_phase = 0; end
      end else if (!m_found) begin
        if (m_count < 511) m_count++;
        if (eve) begin m_found = 1; m_phase = evp; end
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
    model_step();
    check(status === expected_word(), cur_req, status, expected_word());
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_fp();
    fp_mark[cyc] = 1;
    frame_n = 1'b0;
    tick();
    frame_n = 1'b1;
  endtask

  // hi=1: edge in the high half of the period, hi=0: in the low half
  task automatic eval_pulse(input int line, input bit hi);
    if (!hi) #2;
    ev_line[cyc] = line;
    ev_hi[cyc] = hi;
    eval_n[line] = 1'b0;
    tick();
    tick();
    eval_n[line] = 1'b1;
  endtask

  task automatic set_start(input bit v);
    meas_start = v;
    tick();
  endtask

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      fp_mark[i] = 0; ev_line[i] = -1; ev_hi[i] = 0;
    end
    rst_n = 1'b0; frame_n = 1'b1; eval_n = '1; eval_sel = 5'd9; meas_start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 / R2: reset state, select echoed live
    check(status === 16'h4800, "R1", status, 16'h4800);
    rst_n = 1'b1;
    ticks(2);

    // basic measurement: 5 cycles, high half
    cur_req = "R4"; eval_sel = 5'd3;
    set_start(1);
    ticks(4);
    pulse_fp();
    ticks(4);
    eval_pulse(3, 1);
    ticks(28);
    check(status[10] === 1'b0, "R3", status, {status[15:11], 1'b0, status[9:0]});
    pulse_fp();
    ticks(5);
    check(status === {5'd3, 1'b1, 1'b1, 9'd5}, "R4", status, {5'd3, 1'b1, 1'b1, 9'd5});
    check(status[9] === 1'b1, "R5", status, {status[15:10], 1'b1, status[8:0]});
    cur_req = "R8";
    set_start(0);
    tick();
    check(status === {5'd3, 1'b0, 1'b1, 9'd5}, "R8", status, {5'd3, 1'b0, 1'b1, 9'd5});

    // low-half edge after ignored ones
    cur_req = "R6"; eval_sel = 5'd17;
    set_start(1);
    ticks(2);
    eval_pulse(17, 1);          // before the measured frame
    ticks(5);
    pulse_fp();
    ticks(3);
    eval_pulse(9, 1);           // unselected line
    ticks(6);
    eval_pulse(17, 0);          // counted: 12 cycles, low half
    ticks(3);
    eval_pulse(17, 1);          // second edge in frame
    ticks(20);
    pulse_fp();
    ticks(5);
    check(status === {5'd17, 1'b1, 1'b0, 9'd12}, "R6", status, {5'd17, 1'b1, 1'b0, 9'd12});
    check(status[9] === 1'b0, "R5", status, {status[15:10], 1'b0, status[8:0]});

    // start held high after completion
    cur_req = "R9";
    ticks(5);
    pulse_fp();
    ticks(6);
    eval_pulse(17, 1);
    ticks(30);
    pulse_fp();
    ticks(5);
    check(status === {5'd17, 1'b1, 1'b0, 9'd12}, "R9", status, {5'd17, 1'b1, 1'b0, 9'd12});
    set_start(0);
    tick();

    // edge on the same clock as the frame pulse
    cur_req = "R4"; eval_sel = 5'd5;
    set_start(1);
    ticks(4);
    ev_line[cyc] = 5; ev_hi[cyc] = 1; eval_n[5] = 1'b0;
    pulse_fp();
    tick();
    eval_n[5] = 1'b1;
    ticks(30);
    pulse_fp();
    ticks(5);
    check(status === {5'd5, 1'b1, 1'b1, 9'd0}, "R4", status, {5'd5, 1'b1, 1'b1, 9'd0});
    set_start(0);
    tick();

    // no edge in the frame
    cur_req = "R7"; eval_sel = 5'd8;
    set_start(1);
    ticks(4);
    pulse_fp();
    ticks(30);
    pulse_fp();
    ticks(5);
    check(status === {5'd8, 1'b1, 1'b0, 9'd511}, "R7", status, {5'd8, 1'b1, 1'b0, 9'd511});
    set_start(0);
    tick();

    // edge later than the count range
    cur_req = "R7"; eval_sel = 5'd31;
    set_start(1);
    ticks(4);
    pulse_fp();
    ticks(549);
    check(status[8:0] === 9'd511, "R7", status, {status[15:9], 9'd511});
    eval_pulse(31, 1);
    ticks(50);
    pulse_fp();
    ticks(5);
    check(status === {5'd31, 1'b1, 1'b1, 9'd511}, "R7", status, {5'd31, 1'b1, 1'b1, 9'd511});
    set_start(0);
    tick();

    // select changed mid-measurement
    cur_req = "R10"; eval_sel = 5'd2;
    set_start(1);
    ticks(4);
    pulse_fp();
    eval_sel = 5'd20;
    ticks(5);
    eval_pulse(20, 1);
    ticks(2);
    eval_pulse(2, 0);
    ticks(20);
    pulse_fp();
    ticks(5);
    check(status === {5'd20, 1'b1, 1'b0, 9'd10}, "R10", status, {5'd20, 1'b1, 1'b0, 9'd10});
    set_start(0);
    tick();

    // abort while counting
    cur_req = "R8"; eval_sel = 5'd6;
    set_start(1);
    ticks(4);
    pulse_fp();
    ticks(5);
    set_start(0);
    eval_pulse(6, 1);
    ticks(30);
    pulse_fp();
    ticks(5);
    check(status[10] === 1'b0, "R8", status, {status[15:11], 1'b0, status[9:0]});

    // a new start clears the previous result
    cur_req = "R11";
    set_start(1);
    check(status === {5'd6, 1'b0, 1'b0, 9'd0}, "R11", status, {5'd6, 1'b0, 1'b0, 9'd0});
    tick();
    set_start(0);
    ticks(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule